// File: doc/BRIEF.md
# Single-Player Wall-Bounce Game Engine

This block keeps the full state of a one-player paddle game: a square ball that travels across a 640 by 480 playfield, and one vertical bat that slides up and down a fixed column near the left side. Once per video frame, on a frame-tick strobe, it moves the ball and the bat. The bat follows a signed vertical mouse displacement. The ball bounces off the top, right and bottom edges and off the bat. A ball that gets past the bat to the left edge is lost and stays still until the next serve.

A serve request puts the ball just right of the bat column, at a pseudo-random height, and sends it diagonally toward the right. The height comes from a free-running linear feedback shift register. A raster timing generator elsewhere in the chip feeds the current scan coordinate in. The block answers at once whether that pixel is lit. The ball and bat coordinates are also brought out, so that other logic can read them.

Top module: `wallball_engine`

## Requirements
- R1: After synchronous active-low reset, ball_lost is 1, ball_x is 20, ball_y is 236 and bat_y is 208. The ball does not move until a serve arrives.
- R2: On each frame tick, bat_y becomes the old bat_y plus the signed mouse_dy, clamped to the range 0 to 416. Without a frame tick, bat_y does not change, whatever mouse_dy holds.
- R3: A serve, sampled on a clock edge, takes priority over a frame tick. It sets ball_x to 20, sets ball_y to a value in 0 to 472, clears ball_lost, and makes the horizontal direction rightward.
- R4: While the ball is in play, each frame tick moves it by exactly 2 pixels on each axis in its current directions. Without a frame tick, the ball does not move.
- R5: The ball may be moving up with ball_y at most 2, or moving down with ball_y at least 470. On a tick, ball_y is then set to the wall (0 or 472) and the vertical direction reverses.
- R6: The ball may be moving right with ball_x at least 630. On a tick, ball_x is then set to 632 and the horizontal direction reverses.
- R7: The ball may be moving left with ball_x between 20 and 22 inclusive. If, at that tick, rows ball_y to ball_y+7 overlap rows bat_y to bat_y+63 (using bat_y from before the tick), ball_x is set to 20 and the ball moves right.
- R8: Otherwise, a ball moving left with ball_x at most 2 is set to ball_x 0 on the tick and ball_lost goes to 1. Ball position then stays frozen until a serve.
- R9: pixel_on is 1 exactly when (scan_x, scan_y) lies in the 8 by 8 ball square at (ball_x, ball_y) or in the bat rectangle (columns 16 to 19, rows bat_y to bat_y+63). It follows the inputs combinationally.
- R10: Serve heights come from a free-running 16-bit shift register with feedback taps 16, 14, 13 and 11, so serves on different cycles give differing heights.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe per video frame |
| mouse_dy | input | 8 | Signed vertical mouse displacement for this frame |
| serve | input | 1 | Request to place and launch a new ball |
| scan_x | input | 10 | Current raster column |
| scan_y | input | 9 | Current raster row |
| ball_x | output | 10 | Ball left column |
| ball_y | output | 9 | Ball top row |
| bat_y | output | 9 | Bat top row |
| ball_lost | output | 1 | Ball has passed the bat; motion halted |
| pixel_on | output | 1 | Scan coordinate is inside the ball or the bat |

## Verification
The bench builds the block with its default parameters: a 640 by 480 field, a 64-row bat, an 8-pixel ball, a speed of 2 and an 8-bit mouse delta. With a per-frame bat step of up to 127 rows, a few ticks drive the bat into either clamp, and the bench can also keep the bat centred on a ball it models frame by frame. At a speed of 2, a horizontal crossing takes about 306 frames. Within a few thousand clock cycles the bench therefore sees top, bottom and right wall hits, bat returns, and a deliberate miss that ends in the lost state.

// File: rtl/wallball_engine.sv
module wallball_engine #(
  parameter int W      = 640,
  parameter int H      = 480,
  parameter int BAT_X  = 16,
  parameter int BAT_W  = 4,
  parameter int BAT_H  = 64,
  parameter int BALL   = 8,
  parameter int SPEED  = 2,
  parameter int DW     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_tick,
  input  logic signed [DW-1:0]        mouse_dy,
  input  logic                        serve,
  input  logic [$clog2(W)-1:0]        scan_x,
  input  logic [$clog2(H)-1:0]        scan_y,
  output logic [$clog2(W)-1:0]        ball_x,
  output logic [$clog2(H)-1:0]        ball_y,
  output logic [$clog2(H)-1:0]        bat_y,
  output logic                        ball_lost,
  output logic                        pixel_on
);
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam logic [XW-1:0] XMAX    = XW'(W - BALL);
  localparam logic [YW-1:0] YMAX    = YW'(H - BALL);
  localparam logic [YW-1:0] BAT_MAX = YW'(H - BAT_H);
  localparam logic [XW-1:0] SERVE_X = XW'(BAT_X + BAT_W);
  localparam logic [XW-1:0] SPD_X   = XW'(SPEED);
  localparam logic [YW-1:0] SPD_Y   = YW'(SPEED);

  logic [XW-1:0] bx_q, bx_n;
  logic [YW-1:0] by_q, by_n, bat_q, bat_n;
  logic          vx_left_q, vx_left_n, vy_up_q, vy_up_n, lost_q, lost_n;
  logic [15:0]   lfsr_q;
  logic [YW-1:0] serve_raw, serve_y;
  logic          overlap;
  logic signed [YW+1:0] bat_sum;

  assign ball_x    = bx_q;
  assign ball_y    = by_q;
  assign bat_y     = bat_q;
  assign ball_lost = lost_q;

  assign serve_raw = lfsr_q[YW-1:0];
  assign serve_y   = (serve_raw > YMAX) ? serve_raw - YMAX - 1'b1 : serve_raw;

  assign overlap = ({1'b0, by_q} < {1'b0, bat_q} + (YW+1)'(BAT_H)) &&
                   ({1'b0, by_q} + (YW+1)'(BALL) > {1'b0, bat_q});

  assign bat_sum = $signed({2'b00, bat_q}) + (YW+2)'(mouse_dy);
  assign bat_n   = (bat_sum < 0) ? '0 :
                   (bat_sum > $signed({2'b00, BAT_MAX})) ? BAT_MAX : bat_sum[YW-1:0];

  always_comb begin
    bx_n = bx_q; by_n = by_q; vx_left_n = vx_left_q; vy_up_n = vy_up_q; lost_n = lost_q;
    if (vy_up_q) begin
      if (by_q <= SPD_Y) begin by_n = '0; vy_up_n = 1'b0; end
      else by_n = by_q - SPD_Y;
    end else begin
      if (by_q >= YMAX - SPD_Y) begin by_n = YMAX; vy_up_n = 1'b1; end
      else by_n = by_q + SPD_Y;
    end
    if (!vx_left_q) begin
      if (bx_q >= XMAX - SPD_X) begin bx_n = XMAX; vx_left_n = 1'b1; end
      else bx_n = bx_q + SPD_X;
    end else if (bx_q >= SERVE_X && bx_q <= SERVE_X + SPD_X && overlap) begin
      bx_n = SERVE_X; vx_left_n = 1'b0;
    end else if (bx_q <= SPD_X) begin
      bx_n = '0; lost_n = 1'b1;
    end else begin
      bx_n = bx_q - SPD_X;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q    <= 16'hACE1;
      bx_q      <= SERVE_X;
      by_q      <= YW'((H - BALL) / 2);
      bat_q     <= YW'((H - BAT_H) / 2);
      vx_left_q <= 1'b0;
      vy_up_q   <= 1'b0;
      lost_q    <= 1'b1;
    end else begin
      lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      if (frame_tick) bat_q <= bat_n;
      if (serve) begin
        bx_q      <= SERVE_X;
        by_q      <= serve_y;
        vx_left_q <= 1'b0;
        vy_up_q   <= lfsr_q[15];
        lost_q    <= 1'b0;
      end else if (frame_tick && !lost_q) begin
        bx_q      <= bx_n;
        by_q      <= by_n;
        vx_left_q <= vx_left_n;
        vy_up_q   <= vy_up_n;
        lost_q    <= lost_n;
      end
    end
  end

  assign pixel_on =
    (({1'b0, scan_x} >= {1'b0, bx_q}) && ({1'b0, scan_x} < {1'b0, bx_q} + (XW+1)'(BALL)) &&
     ({1'b0, scan_y} >= {1'b0, by_q}) && ({1'b0, scan_y} < {1'b0, by_q} + (YW+1)'(BALL))) ||
    ((scan_x >= XW'(BAT_X)) && (scan_x < XW'(BAT_X + BAT_W)) &&
     ({1'b0, scan_y} >= {1'b0, bat_q}) && ({1'b0, scan_y} < {1'b0, bat_q} + (YW+1)'(BAT_H)));

  a_r2_bat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(bat_y));
  a_r2_bat_range: assert property (@(posedge clk) disable iff (!rst_n)
    bat_y <= BAT_MAX);
  a_r4_ball_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !serve) |=> ($stable(ball_x) && $stable(ball_y)));
  a_r5_y_range: assert property (@(posedge clk) disable iff (!rst_n)
    ball_y <= YMAX);
  a_r6_x_range: assert property (@(posedge clk) disable iff (!rst_n)
    ball_x <= XMAX);
  a_r3_serve_place: assert property (@(posedge clk) disable iff (!rst_n)
    serve |=> (!ball_lost && ball_x == SERVE_X));
  a_r8_lost_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ball_lost && !serve) |=> (ball_lost && $stable(ball_x) && $stable(ball_y)));
  a_r8_lost_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ball_lost) |-> ball_x == '0);
endmodule

// File: tb/sim_wallball_engine.sv
module sim_wallball_engine;
  logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0, serve = 1'b0;
  logic signed [7:0] mouse_dy = '0;
  logic [9:0] scan_x = '0, ball_x;
  logic [8:0] scan_y = '0, ball_y, bat_y;
  logic ball_lost, pixel_on;
  int checks = 0, failures = 0, cycles = 0;
  int mx, my, mvx, mvy, mb, mlost;
  int n_top, n_bot, n_right, n_bat;

  wallball_engine u0 (.clk, .rst_n, .frame_tick, .mouse_dy, .serve, .scan_x, .scan_y,
                      .ball_x, .ball_y, .bat_y, .ball_lost, .pixel_on);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(input int dy);
    int ov, nb;
    ov = (my < mb + 64) && (my + 8 > mb);
    if (!mlost) begin
      if (mvy < 0) begin
        if (my <= 2) begin my = 0; mvy = 1; n_top++; end else my -= 2;
      end else begin
        if (my >= 470) begin my = 472; mvy = -1; n_bot++; end else my += 2;
      end
      if (mvx > 0) begin
        if (mx >= 630) begin mx = 632; mvx = -1; n_right++; end else mx += 2;
      end else if (mx >= 20 && mx <= 22 && ov) begin
        mx = 20; mvx = 1; n_bat++;
      end else if (mx <= 2) begin
        mx = 0; mlost = 1;
      end else mx -= 2;
    end
    nb = mb + dy;
    mb = (nb < 0) ? 0 : (nb > 416) ? 416 : nb;
  endtask

  task automatic hw_tick(input int dy);
    @(negedge clk); mouse_dy = 8'(dy); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic hw_serve();
    @(negedge clk); serve = 1'b1;
    @(negedge clk); serve = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmp_state(input string req);
    chk({req, " ball_x"}, int'(ball_x), mx);
    chk({req, " ball_y"}, int'(ball_y), my);
    chk({req, " bat_y"}, int'(bat_y), mb);
    chk({req, " ball_lost"}, int'(ball_lost), mlost);
  endtask

  task automatic pix(input int x, input int y, input int exp, input string req);
    scan_x = 10'(x); scan_y = 9'(y); #1;
    chk(req, int'(pixel_on), exp);
  endtask

  task automatic do_serve_and_sync();
    int sx, sy, sv, sb, sl;
    hw_serve();
    chk("R3 serve x", int'(ball_x), 20);
    chk("R3 serve lost", int'(ball_lost), 0);
    chk("R3 serve y range", int'(ball_y <= 472), 1);
    mx = ball_x; my = ball_y; mvx = 1; mlost = 0; mb = bat_y;
    sx = mx; sy = my; sb = mb; sl = mlost;
    hw_tick(0);
    sv = 1; mvy = 1; model_step(0);
    if (int'(ball_y) != my) begin
      mx = sx; my = sy; mb = sb; mlost = sl; mvy = -1; model_step(0);
    end
    cmp_state("R4 first move");
    chk("R3 rightward", int'(ball_x), sx + 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mx = 20; my = 236; mb = 208; mlost = 1; mvx = 1; mvy = 1;
    cmp_state("R1 reset");
    hw_tick(0);
    cmp_state("R1 idle until serve");
  endtask

  task automatic t_pixels();
    pix(20, 236, 1, "R9 ball corner");
    pix(27, 243, 1, "R9 ball far corner");
    pix(28, 236, 0, "R9 right of ball");
    pix(24, 244, 0, "R9 below ball");
    pix(16, 208, 1, "R9 bat top-left");
    pix(19, 271, 1, "R9 bat bottom-right");
    pix(15, 208, 0, "R9 left of bat");
    pix(18, 272, 0, "R9 below bat");
    pix(300, 100, 0, "R9 background");
  endtask

  task automatic t_bat_clamp();
    @(negedge clk); mouse_dy = 8'sd100;
    repeat (5) @(negedge clk);
    chk("R2 no tick no move", int'(bat_y), mb);
    for (int i = 0; i < 5; i++) begin hw_tick(-128); model_step(-128); end
    chk("R2 clamp low", int'(bat_y), 0);
    hw_tick(37); model_step(37);
    chk("R2 plain add", int'(bat_y), 37);
    for (int i = 0; i < 6; i++) begin hw_tick(127); model_step(127); end
    chk("R2 clamp high", int'(bat_y), 416);
    hw_tick(-16); model_step(-16);
    chk("R2 step down", int'(bat_y), 400);
  endtask

  task automatic t_serve_variety();
    int ys[4];
    int distinct;
    for (int i = 0; i < 4; i++) begin
      hw_serve();
      repeat (i + 3) @(negedge clk);
      ys[i] = ball_y;
      chk("R10 serve y range", int'(ball_y <= 472), 1);
    end
    distinct = 0;
    for (int i = 1; i < 4; i++) if (ys[i] != ys[0]) distinct = 1;
    chk("R10 heights vary", distinct, 1);
  endtask

  task automatic t_rally();
    int dy, tgt;
    n_top = 0; n_bot = 0; n_right = 0; n_bat = 0;
    do_serve_and_sync();
    for (int f = 0; f < 1400 && n_bat < 2; f++) begin
      tgt = my - 28;
      dy = tgt - mb;
      if (dy > 127) dy = 127;
      if (dy < -128) dy = -128;
      hw_tick(dy); model_step(dy);
      cmp_state("R4 rally frame");
    end
    chk("R5 top wall hit seen", int'(n_top > 0), 1);
    chk("R5 bottom wall hit seen", int'(n_bot > 0), 1);
    chk("R6 right wall hit seen", int'(n_right > 0), 1);
    chk("R7 bat returns seen", int'(n_bat >= 2), 1);
  endtask

  task automatic t_miss();
    int dy, tgt;
    do_serve_and_sync();
    for (int f = 0; f < 800 && !mlost; f++) begin
      tgt = (my < 200) ? 416 : 0;
      dy = tgt - mb;
      if (dy > 127) dy = 127;
      if (dy < -128) dy = -128;
      hw_tick(dy); model_step(dy);
      cmp_state("R8 miss frame");
    end
    chk("R8 lost raised", int'(ball_lost), 1);
    chk("R8 lost at left edge", int'(ball_x), 0);
    for (int i = 0; i < 3; i++) begin hw_tick(5); model_step(5); end
    cmp_state("R8 frozen after loss");
    hw_serve();
    chk("R3 serve after loss clears", int'(ball_lost), 0);
  endtask

  initial begin
    t_reset();
    t_pixels();
    t_bat_clamp();
    t_serve_variety();
    t_rally();
    t_miss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule